// File: doc/BRIEF.md
# Stack-Buffered Backpropagation Weight Updater

This coprocessor-style block computes one synaptic weight update by backpropagation through time. For each timestep of a training sample it holds a surrogate gradient word and a spike status bit. The two are held in a pair of last-in-first-out stores that always move together, so the stored timesteps are consumed newest-first. The stores are filled one entry per push command, or by a loader that walks consecutive words of a memory read port with no further commands. A start command then pops the stores one entry per cycle. On each pop it advances a fixed-point delta recurrence with a 243/256 momentum term. At the end it subtracts a 150/256 learning-rate correction from the held weight.

The block is driven by a six-operation command port with a ready signal. Operands are Q16.16 two's-complement words. A host loads timesteps, starts an update with a weight and an error, and reads the updated weight back with a return command. Updates can be chained with the momentum state carried over, and the weight can be replaced while a computation is running.

Top module: `bptt_weight_unit`

## Requirements
- R1: After reset, busy, overflow, resultValid and memRdEn are 0, cmdReady is 1 and both stores are empty.
- R2: Push (cmdOp 1) stores gradient cmdArgA with spike bit cmdArgB[0] as one entry; entries are consumed in reverse push order.
- R3: For each popped entry (g, s), with error e and previous delta d, the new delta is t = e + ((243·d) >>> 8), then delta = s ? ((t·g) >>> 24) : 0, all wrapping to 32 bits. A zero delta from a spike bit of 0 becomes d for the next entry.
- R4: When popping ends, the weight becomes W − ((150·d) >>> 8), using the final delta d.
- R5: Start (cmdOp 2) loads weight cmdArgA and error cmdArgB, clears the delta to 0, and processes up to cmdSteps entries.
- R6: Resume (cmdOp 3) loads error cmdArgB and processes up to cmdSteps entries. It keeps the current weight (the last updated one) and the current delta.
- R7: Load-weight (cmdOp 4) replaces the weight and is accepted while busy. The final subtraction then uses the new weight.
- R8: Block load (cmdOp 5, base address cmdArgA, count cmdSteps) reads the word at base as a spike mask. It then reads words base+1 … base+count and pushes word base+1+k with mask bit k, in address order.
- R9: Each store holds 32 entries. A push into a full store is dropped, and overflow goes to 1 and stays 1 until reset.
- R10: If the stores run empty before cmdSteps entries have been processed, popping stops and the weight update proceeds with the delta reached so far.
- R11: Busy rises the cycle after a start or resume is accepted and stays high for exactly k+1 cycles, where k is the number of entries popped. While busy, every command except load-weight is held off (cmdReady 0).
- R12: Return-weight (cmdOp 6) is accepted only when not busy. One cycle after acceptance, resultValid pulses for one cycle with resultData equal to the current weight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdOp | input | 3 | Operation code |
| cmdArgA | input | 32 | Gradient, weight or base address |
| cmdArgB | input | 32 | Spike bit (bit 0) or error |
| cmdSteps | input | 6 | Timestep count for start, resume and block load |
| cmdReady | output | 1 | Command accepted on this edge when high with cmdValid |
| memRdEn | output | 1 | Memory read request |
| memAddr | output | 8 | Memory read address |
| memRdata | input | 32 | Read data, valid the cycle after the request |
| busy | output | 1 | Update in progress |
| overflow | output | 1 | Sticky flag for a dropped push |
| resultValid | output | 1 | One-cycle pulse with returned weight |
| resultData | output | 32 | Returned weight |

## Verification
Several situations are hard to reach from the ports. One is a load-weight landing while the recurrence is still running. Another is a return-weight that has to wait out a busy period. The bench reaches both by issuing the second command at the negative edge right after a start is accepted, and it checks that cmdReady falls for the return. A store that runs dry mid-update is reached with a start whose count exceeds the pushed depth. The full store is reached with 33 pushes whose last gradient is large enough that any retention would show in the result. The bench also checks that busy lasts exactly one cycle more than the number of entries actually popped.

// File: rtl/bptt_pkg.sv
package bptt_pkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_PUSH   = 3'd1,
    OP_POPGO  = 3'd2,
    OP_RESUME = 3'd3,
    OP_LOADWT = 3'd4,
    OP_BLKLD  = 3'd5,
    OP_RETWT  = 3'd6
  } opcode_e;

  typedef struct packed {
    logic push;
    logic pushFromMem;
    logic pushSpike;
    logic pop;
    logic loadWt;
    logic loadErr;
    logic clrDelta;
    logic applyUpd;
    logic latchRes;
  } strobe_t;

  localparam int MOMENTUM_NUM = 243;
  localparam int LR_NUM       = 150;

endpackage

// File: rtl/bptt_ctrl.sv
module bptt_ctrl
  import bptt_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AW    = 8,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  input  logic [2:0]      cmdOp,
  input  logic [AW-1:0]   baseIn,
  input  logic            spikeIn,
  input  logic [CNTW-1:0] cmdSteps,
  output logic            cmdReady,
  output logic            memRdEn,
  output logic [AW-1:0]   memAddr,
  input  logic [31:0]     memRdata,
  input  logic            empty,
  output logic            busy,
  output strobe_t         strb
);

  opcode_e           op;
  logic              accept;
  logic              busyQ;
  logic [CNTW-1:0]   stepsLeft;
  logic              ldActive;
  logic [AW-1:0]     ldBase;
  logic [CNTW:0]     ldIssue, ldGot, ldTotal;
  logic              rdPendQ;
  logic [31:0]       maskQ;

  assign op       = opcode_e'(cmdOp);
  assign cmdReady = !ldActive && (!busyQ || op == OP_LOADWT);
  assign accept   = cmdValid && cmdReady;
  assign busy     = busyQ;
  assign memRdEn  = ldActive && (ldIssue < ldTotal);
  assign memAddr  = ldBase + ldIssue[AW-1:0];

  always_comb begin
    strb = '0;
    if (accept) begin
      case (op)
        OP_PUSH:   begin strb.push = 1'b1; strb.pushSpike = spikeIn; end
        OP_POPGO:  begin strb.loadWt = 1'b1; strb.loadErr = 1'b1; strb.clrDelta = 1'b1; end
        OP_RESUME: strb.loadErr = 1'b1;
        OP_LOADWT: strb.loadWt = 1'b1;
        OP_RETWT:  strb.latchRes = 1'b1;
        default:   ;
      endcase
    end
    if (busyQ) begin
      if (stepsLeft != '0 && !empty) strb.pop = 1'b1;
      else                           strb.applyUpd = 1'b1;
    end
    if (rdPendQ && ldGot != '0) begin
      strb.push        = 1'b1;
      strb.pushFromMem = 1'b1;
      strb.pushSpike   = maskQ[0];
    end
  end

  // Update sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ     <= 1'b0;
      stepsLeft <= '0;
    end else if (accept && (op == OP_POPGO || op == OP_RESUME)) begin
      busyQ     <= 1'b1;
      stepsLeft <= cmdSteps;
    end else if (busyQ) begin
      if (strb.pop) stepsLeft <= stepsLeft - 1'b1;
      else          busyQ     <= 1'b0;
    end
  end

  // Memory-to-store loader
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ldActive <= 1'b0;
      ldBase   <= '0;
      ldIssue  <= '0;
      ldGot    <= '0;
      ldTotal  <= '0;
      rdPendQ  <= 1'b0;
      maskQ    <= '0;
    end else begin
      rdPendQ <= memRdEn;
      if (accept && op == OP_BLKLD) begin
        ldActive <= 1'b1;
        ldBase   <= baseIn;
        ldIssue  <= '0;
        ldGot    <= '0;
        ldTotal  <= {1'b0, cmdSteps} + 1'b1;
      end else if (ldActive) begin
        if (memRdEn) ldIssue <= ldIssue + 1'b1;
        if (rdPendQ) begin
          if (ldGot == '0) maskQ <= memRdata;
          else             maskQ <= {1'b0, maskQ[31:1]};
          ldGot <= ldGot + 1'b1;
          if (ldGot == ldTotal - 1'b1) ldActive <= 1'b0;
        end
      end
    end
  end

  // R11
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && (op == OP_POPGO || op == OP_RESUME)) |=> busyQ);

  // R8
  ld_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> !busyQ);

  // R8
  ld_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && $past(memRdEn)) |-> memAddr == $past(memAddr) + 1'b1);

endmodule

// File: rtl/bptt_datapath.sv
module bptt_datapath
  import bptt_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     strb,
  input  logic [31:0] argA,
  input  logic [31:0] argB,
  input  logic [31:0] memRdata,
  output logic        empty,
  output logic        overflow,
  output logic        resultValid,
  output logic [31:0] resultData
);

  logic [31:0]         gradMem [DEPTH];
  logic [DEPTH-1:0]    spikeQ;
  logic [CNTW-1:0]     depthQ;
  logic signed [31:0]  deltaQ, errQ, weightQ;
  logic                ovfQ, resValidQ;
  logic [31:0]         resDataQ;

  logic                full, doPush;
  logic [31:0]         pushGrad;
  logic signed [31:0]  topGrad;
  logic                topSpike;
  logic signed [63:0]  momProd, stepProd, corrProd;
  logic signed [31:0]  momTerm, sumT, newDelta, wBase, newWeight;

  assign empty    = (depthQ == '0);
  assign full     = (depthQ == CNTW'(DEPTH));
  assign doPush   = strb.push && !full;
  assign pushGrad = strb.pushFromMem ? memRdata : argA;
  assign topGrad  = gradMem[depthQ - 1'b1];
  assign topSpike = spikeQ[0];

  always_comb begin
    momProd   = 64'(deltaQ) * 64'sd243;
    momTerm   = 32'(momProd >>> 8);
    sumT      = errQ + momTerm;
    stepProd  = 64'(sumT) * 64'(topGrad);
    newDelta  = topSpike ? 32'(stepProd >>> 24) : 32'sd0;
    corrProd  = 64'(deltaQ) * 64'sd150;
    wBase     = strb.loadWt ? argA : weightQ;
    newWeight = wBase - 32'(corrProd >>> 8);
  end

  always_ff @(posedge clk) begin
    if (doPush) gradMem[depthQ] <= pushGrad;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spikeQ    <= '0;
      depthQ    <= '0;
      deltaQ    <= '0;
      errQ      <= '0;
      weightQ   <= '0;
      ovfQ      <= 1'b0;
      resValidQ <= 1'b0;
      resDataQ  <= '0;
    end else begin
      resValidQ <= strb.latchRes;
      if (strb.latchRes) resDataQ <= weightQ;
      if (strb.push && full) ovfQ <= 1'b1;
      if (doPush) begin
        spikeQ <= {spikeQ[DEPTH-2:0], strb.pushSpike};
        depthQ <= depthQ + 1'b1;
      end else if (strb.pop) begin
        spikeQ <= {1'b0, spikeQ[DEPTH-1:1]};
        depthQ <= depthQ - 1'b1;
      end
      if (strb.loadErr) errQ <= argB;
      if (strb.clrDelta)  deltaQ <= '0;
      else if (strb.pop)  deltaQ <= newDelta;
      if (strb.applyUpd)    weightQ <= newWeight;
      else if (strb.loadWt) weightQ <= argA;
    end
  end

  assign overflow    = ovfQ;
  assign resultValid = resValidQ;
  assign resultData  = resDataQ;

  // R9
  depth_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    depthQ <= CNTW'(DEPTH));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfQ |=> ovfQ);

  // R10
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |-> depthQ != '0);

  // R12
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchRes |=> resValidQ);

endmodule

// File: rtl/bptt_weight_unit.sv
module bptt_weight_unit
  import bptt_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AW    = 8,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  input  logic [2:0]      cmdOp,
  input  logic [31:0]     cmdArgA,
  input  logic [31:0]     cmdArgB,
  input  logic [CNTW-1:0] cmdSteps,
  output logic            cmdReady,
  output logic            memRdEn,
  output logic [AW-1:0]   memAddr,
  input  logic [31:0]     memRdata,
  output logic            busy,
  output logic            overflow,
  output logic            resultValid,
  output logic [31:0]     resultData
);

  strobe_t strb;
  logic    empty;

  bptt_ctrl #(.DEPTH(DEPTH), .AW(AW)) uCtrl (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdOp(cmdOp),
    .baseIn(cmdArgA[AW-1:0]), .spikeIn(cmdArgB[0]), .cmdSteps(cmdSteps),
    .cmdReady(cmdReady),
    .memRdEn(memRdEn), .memAddr(memAddr), .memRdata(memRdata),
    .empty(empty), .busy(busy), .strb(strb)
  );

  bptt_datapath #(.DEPTH(DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .argA(cmdArgA), .argB(cmdArgB), .memRdata(memRdata),
    .empty(empty), .overflow(overflow),
    .resultValid(resultValid), .resultData(resultData)
  );

endmodule

// File: tb/tb_bptt_weight_unit.sv
module tb_bptt_weight_unit;
  import bptt_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdOp = 3'd0;
  logic [31:0] cmdArgA = '0, cmdArgB = '0;
  logic [5:0]  cmdSteps = '0;
  logic        cmdReady, memRdEn, busy, overflow, resultValid;
  logic [7:0]  memAddr;
  logic [31:0] memRdata, resultData;
  logic [31:0] mem [256];

  int compared = 0, mismatched = 0;
  int mg [64];
  bit ms [64];
  int md = 0;
  int mDelta = 0, mErr = 0, mW = 0, mPopped = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) if (memRdEn) memRdata <= mem[memAddr];

  bptt_weight_unit dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdArgA(cmdArgA), .cmdArgB(cmdArgB), .cmdSteps(cmdSteps),
    .cmdReady(cmdReady), .memRdEn(memRdEn), .memAddr(memAddr),
    .memRdata(memRdata), .busy(busy), .overflow(overflow),
    .resultValid(resultValid), .resultData(resultData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int stepDelta(int d, int e, int g, bit s);
    longint mom = (longint'(d) * 243) >>> 8;
    int t = e + int'(mom);
    longint p = longint'(t) * longint'(g);
    return s ? int'(p >>> 24) : 0;
  endfunction

  function automatic void mPush(int g, bit s);
    if (md < 32) begin mg[md] = g; ms[md] = s; md++; end
  endfunction

  function automatic void mRun(int steps);
    mPopped = 0;
    while (steps > 0 && md > 0) begin
      md--;
      mDelta = stepDelta(mDelta, mErr, mg[md], ms[md]);
      steps--; mPopped++;
    end
    mW = mW - int'((longint'(mDelta) * 150) >>> 8);
  endfunction

  // drive at negedge; returns at the negedge after the accepting edge
  task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b, input int n);
    cmdValid = 1'b1; cmdOp = op; cmdArgA = a; cmdArgB = b; cmdSteps = 6'(n);
    #1;
    while (!cmdReady) begin @(negedge clk); #1; end
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 3'd0;
  endtask

  task automatic waitIdle(input string req);
    int cyc = 0;
    chk({req, " busy after start"}, 32'(busy), 32'd1);
    while (busy) begin @(negedge clk); cyc++; end
    chk({req, " R11 busy length"}, cyc, mPopped + 1);
  endtask

  task automatic readW(input string req, input int exp);
    issue(OP_RETWT, 0, 0, 0);
    chk({req, " R12 resultValid"}, 32'(resultValid), 32'd1);
    chk(req, resultData, exp);
    @(negedge clk);
    chk({req, " R12 single pulse"}, 32'(resultValid), 32'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 overflow", 32'(overflow), 0);
    chk("R1 resultValid", 32'(resultValid), 0);
    chk("R1 cmdReady", 32'(cmdReady), 1);
    chk("R1 memRdEn", 32'(memRdEn), 0);

    // R2 R3 R4 R5 sweep over spike patterns, lengths and signs
    for (int p = 0; p < 8; p++) begin
      for (int li = 0; li < 3; li++) begin
        int n = (li == 0) ? 1 : (li == 1) ? 5 : 16;
        int w0 = 32'h0002_0000 + p * 32'h0000_1234;
        int e0 = (p[0] ? -1 : 1) * (32'h0000_8000 + p * 32'h0000_0777);
        for (int i = 0; i < n; i++) begin
          int g = 32'h0000_3000 + i * 32'h0000_0911 + p * 32'h0000_0100;
          bit s = ((i + p) % 3 != 0) || (p == 7);
          issue(OP_PUSH, g, {31'd0, s}, 0);
          mPush(g, s);
        end
        mW = w0; mErr = e0; mDelta = 0;
        issue(OP_POPGO, w0, e0, n);
        mRun(n);
        waitIdle("R5");
        readW("R2 R3 R4 sweep weight", mW);
      end
    end

    // R6 resume chaining: delta and weight carry over
    for (int i = 0; i < 4; i++) begin
      issue(OP_PUSH, 32'h0000_6000 + i * 32'h0000_2000, 1, 0);
      mPush(32'h0000_6000 + i * 32'h0000_2000, 1);
    end
    mW = 32'h0001_0000; mErr = 32'h0000_C000; mDelta = 0;
    issue(OP_POPGO, mW, mErr, 2); mRun(2); waitIdle("R5");
    mErr = -32'h0000_4000;
    issue(OP_RESUME, 32'hDEAD_BEEF, mErr, 2); mRun(2); waitIdle("R6");
    readW("R6 resume weight", mW);

    // R7 load weight while busy
    for (int i = 0; i < 16; i++) begin
      issue(OP_PUSH, 32'h0000_5000 + i * 32'h300, 1, 0);
      mPush(32'h0000_5000 + i * 32'h300, 1);
    end
    mErr = 32'h0001_0000; mDelta = 0;
    issue(OP_POPGO, 32'h0003_0000, mErr, 16);
    issue(OP_LOADWT, 32'h0007_0000, 0, 0);
    mW = 32'h0007_0000; mRun(16);
    while (busy) @(negedge clk);
    readW("R7 reloaded weight", mW);

    // R11 R12 return-weight stalls while busy
    for (int i = 0; i < 8; i++) begin
      issue(OP_PUSH, 32'h0000_4400 + i * 32'h500, {31'd0, i[0]}, 0);
      mPush(32'h0000_4400 + i * 32'h500, i[0]);
    end
    mW = 32'h0000_9000; mErr = -32'h0000_9000; mDelta = 0;
    issue(OP_POPGO, mW, mErr, 8); mRun(8);
    cmdValid = 1'b1; cmdOp = OP_RETWT; #1;
    chk("R11 return held off while busy", 32'(cmdReady), 0);
    cmdValid = 1'b0;
    readW("R11 stalled return", mW);

    // R8 block load from memory
    mem[8'h20] = 32'hA5C3_5A96;
    for (int i = 0; i < 16; i++) mem[8'h21 + i] = 32'h0000_3800 + i * 32'h0000_0440;
    issue(OP_BLKLD, 32'h20, 0, 16);
    for (int i = 0; i < 16; i++) mPush(mem[8'h21 + i], mem[8'h20][i]);
    mW = 32'h0004_0000; mErr = 32'h0000_A000; mDelta = 0;
    issue(OP_POPGO, mW, mErr, 16); mRun(16); waitIdle("R8");
    readW("R8 block load weight", mW);

    // R9 overflow: 33rd push dropped
    for (int i = 0; i < 33; i++) begin
      int g = (i == 32) ? 32'h0100_0000 : 32'h0000_2000 + i * 32'h100;
      issue(OP_PUSH, g, 1, 0);
      mPush(g, 1);
    end
    chk("R9 overflow set", 32'(overflow), 1);
    mW = 32'h0002_0000; mErr = 32'h0000_3000; mDelta = 0;
    issue(OP_POPGO, mW, mErr, 33); mRun(33); waitIdle("R9");
    readW("R9 dropped push weight", mW);
    chk("R9 overflow sticky", 32'(overflow), 1);

    // R10 early stop on empty store
    for (int i = 0; i < 3; i++) begin
      issue(OP_PUSH, 32'h0000_7000 - i * 32'h1000, 1, 0);
      mPush(32'h0000_7000 - i * 32'h1000, 1);
    end
    mW = 32'h0005_0000; mErr = 32'h0000_8000; mDelta = 0;
    issue(OP_POPGO, mW, mErr, 10); mRun(10); waitIdle("R10");
    readW("R10 early stop weight", mW);
    mW = 32'h0006_0000; mErr = 32'h0001_0000; mDelta = 0;
    issue(OP_POPGO, mW, mErr, 2); mRun(2); waitIdle("R10");
    readW("R10 empty store keeps weight", 32'h0006_0000);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule